// File: doc/BRIEF.md
# Direction-Selectable Self-Synchronizing Scrambler Pair

This block whitens a serial bit stream before it is mapped to line symbols, and undoes that whitening at the far end. It holds two copies of one shift-register core. The transmit copy scrambles. The receive copy descrambles. Each core keeps the last 23 line bits. An outgoing bit is the incoming bit XORed with two of those stored bits. One stored bit is always the oldest, at delay 23. The other is at delay 5 or delay 18, picked by a static direction input. The transmit core stores the bits it sends. The receive core stores the bits it receives. Because of this, the receive core locks onto any transmitter within 23 valid bits, and no seed has to be shared.

Each path has a bit-valid qualifier. A core advances only on a valid bit, and its output is registered one cycle after the input. Each path also has a bypass control. Under bypass a bit goes through unchanged, so a framing layer can send fixed symbol patterns such as alternating extremes. The register keeps recording the line bits during bypass, so both ends stay in step when bypass ends.

Top module: `selfsync_scrambler_pair`

## Requirements
- R1: While `rst_n` is low, both output valids and both output bits read 0 and both history registers are cleared. After reset, a transmit stream of all-zero bits therefore scrambles to all zeros.
- R2: Each output valid equals its input valid one clock earlier (one register stage).
- R3: With `dir_sel`=0, bypass low and a valid input, the transmit output is the input bit XOR the transmit line bit sent 5 valid bits earlier XOR the one sent 23 valid bits earlier. Line bits from before reset count as 0.
- R4: With `dir_sel`=1, the same rule applies but the shorter delay is 18 instead of 5.
- R5: With the receive input fed from the transmit output, the receive output equals the original data for every bit after the first 23 received. This holds even when the receive register starts in a different state.
- R6: With bypass low, the receive output is the received bit XOR the received bit at the selected shorter delay (5 or 18) XOR the received bit at delay 23.
- R7: A cycle without input valid leaves the output bit unchanged and does not advance the history, so later outputs are as if that cycle never happened.
- R8: With bypass high on a valid bit, the output bit equals the input bit unchanged, on both paths.
- R9: During bypass the line bit (the sent bit on transmit, the received bit on receive) still enters the history. The outputs right after bypass ends therefore follow R3, R4 and R6 with those bits included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_sel | input | 1 | Static tap choice: 0 selects delays 5/23, 1 selects delays 18/23 |
| tx_bypass | input | 1 | Transmit path passes data unscrambled |
| tx_in_vld | input | 1 | Transmit data bit valid |
| tx_in_bit | input | 1 | Transmit data bit |
| tx_out_vld | output | 1 | Scrambled bit valid |
| tx_out_bit | output | 1 | Scrambled line bit |
| rx_bypass | input | 1 | Receive path passes data undescrambled |
| rx_in_vld | input | 1 | Received line bit valid |
| rx_in_bit | input | 1 | Received line bit |
| rx_out_vld | output | 1 | Recovered bit valid |
| rx_out_bit | output | 1 | Recovered data bit |

## Verification
A run of zeros right after reset shows that a cleared register adds nothing. Random data with random valid gaps, under each tap setting, separates the delay-5 taps from the delay-18 taps, and also catches any history that moves on idle cycles. The receive path first takes a burst of junk bits and is then looped to the transmit output. Correct data appearing after exactly 23 loopback bits shows self-synchronization from a mismatched start. An alternating pattern sent under bypass, followed by normal traffic, checks the pass-through and shows whether bypassed bits were recorded in the history.

// File: rtl/sss_pkg.sv
package sss_pkg;
  typedef enum logic {
    DIR_M2S = 1'b0,
    DIR_S2M = 1'b1
  } sss_dir_e;

  // three-way exclusive OR used by both the scrambler and descrambler
  function automatic logic sss_mix(input logic data_b, input logic tap_a, input logic tap_b);
    return data_b ^ tap_a ^ tap_b;
  endfunction
endpackage

// File: rtl/sss_tap_sel.sv
module sss_tap_sel
  import sss_pkg::*;
#(
  parameter int ORDER = 23,
  parameter int TAP_M2S = 5,
  parameter int TAP_S2M = 18
) (
  input  logic [ORDER-1:0] hist,
  input  logic             dir_sel,
  output logic             tap_short,
  output logic             tap_long
);
  localparam int IDX_M2S = TAP_M2S - 1;
  localparam int IDX_S2M = TAP_S2M - 1;
  localparam int IDX_LONG = ORDER - 1;

  assign tap_long  = hist[IDX_LONG];
  assign tap_short = (dir_sel == DIR_S2M) ? hist[IDX_S2M] : hist[IDX_M2S];
endmodule

// File: rtl/sss_core.sv
module sss_core
  import sss_pkg::*;
#(
  parameter int ORDER = 23,
  parameter int TAP_M2S = 5,
  parameter int TAP_S2M = 18,
  parameter bit DESCRAMBLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_sel,
  input  logic bypass,
  input  logic in_vld,
  input  logic in_bit,
  output logic out_vld,
  output logic out_bit
);
  logic [ORDER-1:0] hist_q;
  logic             tap_short;
  logic             tap_long;
  logic             work_bit;
  logic             line_bit;

  sss_tap_sel #(.ORDER(ORDER), .TAP_M2S(TAP_M2S), .TAP_S2M(TAP_S2M)) u_taps (
    .hist(hist_q), .dir_sel(dir_sel), .tap_short(tap_short), .tap_long(tap_long)
  );

  assign work_bit = bypass ? in_bit : sss_mix(in_bit, tap_short, tap_long);

  // the bit that enters the history is always the one on the line
  generate
    if (DESCRAMBLE) begin : g_rx
      assign line_bit = in_bit;
    end else begin : g_tx
      assign line_bit = work_bit;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      out_vld <= 1'b0;
      out_bit <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        hist_q  <= {hist_q[ORDER-2:0], line_bit};
        out_bit <= work_bit;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (hist_q == '0 && !out_vld && !out_bit));

  p_vld_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  p_vld_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_bit) && $stable(hist_q)));

  p_bypass_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && bypass) |=> (out_bit == $past(in_bit)));

  generate
    if (DESCRAMBLE) begin : g_chk_rx
      p_hist_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (hist_q[0] == $past(in_bit)));
    end else begin : g_chk_tx
      p_hist_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (hist_q[0] == out_bit));
    end
  endgenerate
endmodule

// File: rtl/selfsync_scrambler_pair.sv
module selfsync_scrambler_pair #(
  parameter int ORDER = 23,
  parameter int TAP_M2S = 5,
  parameter int TAP_S2M = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_sel,
  input  logic tx_bypass,
  input  logic tx_in_vld,
  input  logic tx_in_bit,
  output logic tx_out_vld,
  output logic tx_out_bit,
  input  logic rx_bypass,
  input  logic rx_in_vld,
  input  logic rx_in_bit,
  output logic rx_out_vld,
  output logic rx_out_bit
);
  sss_core #(.ORDER(ORDER), .TAP_M2S(TAP_M2S), .TAP_S2M(TAP_S2M), .DESCRAMBLE(1'b0)) u_tx (
    .clk(clk), .rst_n(rst_n), .dir_sel(dir_sel), .bypass(tx_bypass),
    .in_vld(tx_in_vld), .in_bit(tx_in_bit), .out_vld(tx_out_vld), .out_bit(tx_out_bit)
  );

  sss_core #(.ORDER(ORDER), .TAP_M2S(TAP_M2S), .TAP_S2M(TAP_S2M), .DESCRAMBLE(1'b1)) u_rx (
    .clk(clk), .rst_n(rst_n), .dir_sel(dir_sel), .bypass(rx_bypass),
    .in_vld(rx_in_vld), .in_bit(rx_in_bit), .out_vld(rx_out_vld), .out_bit(rx_out_bit)
  );
endmodule

// File: tb/sim_selfsync_scrambler_pair.sv
module sim_selfsync_scrambler_pair;
  localparam int CLK_P = 10;
  localparam int ORDER = 23;
  localparam int TM = 5;
  localparam int TS = 18;
  localparam int MAXN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_sel = 1'b0;
  logic tx_bypass = 1'b0, tx_in_vld = 1'b0, tx_in_bit = 1'b0;
  logic rx_bypass = 1'b0, rx_in_vld = 1'b0, rx_in_bit = 1'b0;
  logic tx_out_vld, tx_out_bit, rx_out_vld, rx_out_bit;

  bit tx_line [MAXN];
  bit rx_line [MAXN];
  int tx_n, rx_n;
  int checks = 0, errors = 0;
  bit last_tx, last_rx;
  int lb_cnt;
  bit p_vld, p_bit, p_byp, p_data;

  always #(CLK_P/2) clk = ~clk;

  selfsync_scrambler_pair u0 (
    .clk(clk), .rst_n(rst_n), .dir_sel(dir_sel),
    .tx_bypass(tx_bypass), .tx_in_vld(tx_in_vld), .tx_in_bit(tx_in_bit),
    .tx_out_vld(tx_out_vld), .tx_out_bit(tx_out_bit),
    .rx_bypass(rx_bypass), .rx_in_vld(rx_in_vld), .rx_in_bit(rx_in_bit),
    .rx_out_vld(rx_out_vld), .rx_out_bit(rx_out_bit)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit tx_ago(input int k);
    return (tx_n >= k) ? tx_line[tx_n-k] : 1'b0;
  endfunction

  function automatic bit rx_ago(input int k);
    return (rx_n >= k) ? rx_line[rx_n-k] : 1'b0;
  endfunction

  task automatic do_reset(input bit dir);
    @(negedge clk);
    rst_n = 1'b0; dir_sel = dir;
    tx_in_vld = 1'b0; rx_in_vld = 1'b0; tx_bypass = 1'b0; rx_bypass = 1'b0;
    tx_n = 0; rx_n = 0; last_tx = 0; last_rx = 0; lb_cnt = 0;
    p_vld = 0; p_bit = 0; p_byp = 0; p_data = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 tx_out_vld", tx_out_vld, 1'b0);
    chk("R1 rx_out_vld", rx_out_vld, 1'b0);
    chk("R1 tx_out_bit", tx_out_bit, 1'b0);
    chk("R1 rx_out_bit", rx_out_bit, 1'b0);
    rst_n = 1'b1;
  endtask

  // one clock: transmit inputs plus receive inputs; rlb marks loopback bits
  task automatic step(input string req, input bit tv, input bit td, input bit tb,
                      input bit rv, input bit rd, input bit rb, input bit rlb, input bit rdata);
    int tap;
    bit e_tx, e_rx;
    @(negedge clk);
    tx_in_vld = tv; tx_in_bit = td; tx_bypass = tb;
    rx_in_vld = rv; rx_in_bit = rd; rx_bypass = rb;
    tap = dir_sel ? TS : TM;
    e_tx = tb ? td : (td ^ tx_ago(tap) ^ tx_ago(ORDER));
    e_rx = rb ? rd : (rd ^ rx_ago(tap) ^ rx_ago(ORDER));
    @(posedge clk); #1;
    chk("R2 tx valid", tx_out_vld, tv);
    chk("R2 rx valid", rx_out_vld, rv);
    if (tv) begin
      chk(tb ? "R8 tx bypass" : req, tx_out_bit, e_tx);
      tx_line[tx_n] = e_tx; tx_n++;
    end else begin
      chk("R7 tx hold", tx_out_bit, last_tx);
    end
    if (rv) begin
      chk(rb ? "R8 rx bypass" : "R6 descramble", rx_out_bit, e_rx);
      if (rlb && lb_cnt >= ORDER) chk("R5 recovered data", rx_out_bit, rdata);
      if (rlb) lb_cnt++;
      rx_line[rx_n] = rd; rx_n++;
    end else begin
      chk("R7 rx hold", rx_out_bit, last_rx);
    end
    last_tx = tx_out_bit; last_rx = rx_out_bit;
  endtask

  task automatic loop_step(input string req, input bit tv, input bit td, input bit tb);
    bit cur_vld, cur_byp, cur_data;
    cur_vld = p_vld; cur_byp = p_byp; cur_data = p_data;
    step(req, tv, td, tb, cur_vld, p_bit, cur_byp, 1'b1, cur_data);
    p_vld = tv; p_bit = tx_out_bit; p_byp = tb; p_data = td;
  endtask

  task automatic run_dir(input bit dir, input string req);
    do_reset(dir);
    for (int i = 0; i < 30; i++) loop_step("R1 zero stream", 1'b1, 1'b0, 1'b0);
    do_reset(dir);
    // junk into the receiver only, so its start state differs
    for (int i = 0; i < 30; i++)
      step("R7 tx idle", 1'b0, 1'b0, 1'b0, 1'b1, 1'($urandom_range(0, 1)), 1'b0, 1'b0, 1'b0);
    lb_cnt = 0;
    for (int i = 0; i < 300; i++)
      loop_step(req, ($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), 1'b0);
    for (int i = 0; i < 24; i++)
      loop_step("R8 bypass", 1'b1, ((i % 4) < 2), 1'b1);
    for (int i = 0; i < 80; i++)
      loop_step("R9 after bypass", ($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)), 1'b0);
    loop_step("R9 drain", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    run_dir(1'b0, "R3 taps 5/23");
    run_dir(1'b1, "R4 taps 18/23");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule